// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits and returns their full `2*WIDTH`-bit signed product. It uses radix-2 Booth recoding and runs one recoding step per clock. In each step the two lowest bits of the shifting multiplier window select one of three actions. The block then adds the multiplicand into a partial-product accumulator, subtracts it, or leaves the accumulator as it is. In the same clock, the accumulator, the multiplier register and a one-bit extension below the multiplier shift right arithmetically by one place.

A client drives both operands and pulses `start` while the block is idle. The operands are captured on that edge. Exactly `WIDTH` clocks later, `done` is high for one cycle and `product` carries the result. The result stays on `product` until the next multiply completes. There is no back-pressure. The block accepts a request only when it is idle, and a `start` seen while it is busy is dropped without any effect. The client must therefore wait for `done` before issuing the next request. Operands are only sampled on the accepting edge.

Top module: `booth_seq_mul`

## Requirements
- R1: While reset is held and on the first cycle after it, `product` is 0 and `done` is 0.
- R2: A `start` seen on a clock edge while idle captures both operands. `done` rises after exactly `WIDTH` further clock edges.
- R3: For every pair of signed operands, `product` at `done` equals the signed product of `multiplicand` and `multiplier`, sign-extended to `2*WIDTH` bits. Examples: 5 × −7 gives −35, and 5 × 7 gives 35.
- R4: The most negative operand value is multiplied correctly in either position, including when both operands hold it. At 4 bits: −8 × −8 = 64, −8 × 7 = −56, and 7 × −8 = −56.
- R5: `done` is high for exactly one cycle per accepted request.
- R6: A `start` arriving while a multiply is in progress is ignored. The running result and its completion time are unchanged, and no second `done` follows.
- R7: `product` changes only in the cycle in which `done` is high. It holds its value through idle cycles and throughout the next multiply.
- R8: Recoding uses bit 0 of the multiplier window together with the extension bit below it. For the pair (bit0, extension): 01 adds the multiplicand, 10 subtracts it, and 00 or 11 does nothing. The extension bit starts at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, honoured only while idle |
| multiplicand | input | WIDTH | Signed multiplicand, sampled on the accepting edge |
| multiplier | input | WIDTH | Signed multiplier, sampled on the accepting edge |
| product | output | 2*WIDTH | Signed product, held between completions |
| done | output | 1 | One-cycle completion strobe |

## Verification
The hardest case to reach from the ports is a `start` arriving while the block is busy, in the last busy cycle. There the drop rule and the completion edge coincide. The stimulus keeps `start` raised with different operand values on every busy cycle of some runs, including the final one. It then confirms that the result belongs to the first operands, that `done` arrives on time and only once, and that the block is idle afterwards. The most negative operand needs one extra accumulator bit to avoid overflow. The exhaustive sweep of all 4-bit pairs forces it through both the add and the subtract path.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef enum logic [1:0] {
    BOP_KEEP = 2'd0,
    BOP_ADD  = 2'd1,
    BOP_SUB  = 2'd2
  } booth_op_e;

endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic      win_lsb,
  input  logic      win_ext,
  output booth_op_e op
);

  // R8: the pair (lsb, ext) picks the step action
  always_comb begin
    unique case ({win_lsb, win_ext})
      2'b01:   op = BOP_ADD;
      2'b10:   op = BOP_SUB;
      default: op = BOP_KEEP;
    endcase
  end

endmodule

// File: rtl/booth_step.sv
module booth_step
  import booth_pkg::*;
#(
  parameter int WIDTH = 4,
  localparam int AW = WIDTH + 1
) (
  input  logic [AW-1:0]    acc_in,
  input  logic [WIDTH-1:0] win_in,
  input  logic             ext_in,
  input  logic [AW-1:0]    mc_ext,
  input  booth_op_e        op,
  output logic [AW-1:0]    acc_out,
  output logic [WIDTH-1:0] win_out,
  output logic             ext_out
);

  logic [AW-1:0] sum;

  always_comb begin
    unique case (op)
      BOP_ADD: sum = acc_in + mc_ext;
      BOP_SUB: sum = acc_in - mc_ext;
      default: sum = acc_in;
    endcase
  end

  // arithmetic right shift of {acc, win, ext}
  assign acc_out = {sum[AW-1], sum[AW-1:1]};
  assign win_out = {sum[0], win_in[WIDTH-1:1]};
  assign ext_out = win_in[0];

endmodule

// File: rtl/booth_seq_ctrl.sv
module booth_seq_ctrl #(
  parameter int WIDTH = 4,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          load,
  output logic          step,
  output logic          finish,
  output logic [CW-1:0] count
);

  localparam logic [CW-1:0] CNT_INIT = CW'(WIDTH);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  assign load   = start && !busy;
  assign step   = busy;
  assign finish = busy && (count == CNT_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      count <= '0;
    end else if (load) begin
      busy  <= 1'b1;
      count <= CNT_INIT;
    end else if (step) begin
      count <= count - CNT_ONE;
      if (finish) busy <= 1'b0;
    end
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy && count == CNT_INIT);

  assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (count != '0) && (count <= CNT_INIT));

  assert_busy_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && count != CNT_ONE |=> busy && count == $past(count) - CNT_ONE);

endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
  import booth_pkg::*;
#(
  parameter int WIDTH = 4,
  localparam int AW = WIDTH + 1,
  localparam int PW = 2 * WIDTH,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] multiplicand,
  input  logic [WIDTH-1:0] multiplier,
  output logic [PW-1:0]    product,
  output logic             done
);

  logic          busy, load, step, finish;
  logic [CW-1:0] count;
  logic [AW-1:0] mc_r, acc_r, acc_n;
  logic [WIDTH-1:0] win_r, win_n;
  logic          ext_r, ext_n;
  booth_op_e     op;

  booth_seq_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .load(load), .step(step), .finish(finish), .count(count)
  );

  booth_recode u_rec (.win_lsb(win_r[0]), .win_ext(ext_r), .op(op));

  booth_step #(.WIDTH(WIDTH)) u_step (
    .acc_in(acc_r), .win_in(win_r), .ext_in(ext_r), .mc_ext(mc_r), .op(op),
    .acc_out(acc_n), .win_out(win_n), .ext_out(ext_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_r  <= '0;
      acc_r <= '0;
      win_r <= '0;
      ext_r <= 1'b0;
    end else if (load) begin
      mc_r  <= {multiplicand[WIDTH-1], multiplicand};
      acc_r <= '0;
      win_r <= multiplier;
      ext_r <= 1'b0;
    end else if (step) begin
      acc_r <= acc_n;
      win_r <= win_n;
      ext_r <= ext_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      product <= '0;
      done    <= 1'b0;
    end else begin
      done <= finish;
      if (finish) product <= {acc_n[WIDTH-1:0], win_n};
    end
  end

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_product_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(product));

  assert_done_after_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy) && !busy);

  assert_ext_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !ext_r && acc_r == '0);

endmodule

// File: tb/tb_booth_seq_mul.sv
`timescale 1ns/1ps
module tb_booth_seq_mul;
  localparam int W = 4;
  localparam int P = 2 * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] mcand = '0, mplier = '0;
  logic [P-1:0] product;
  logic done;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  booth_seq_mul #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .multiplicand(mcand),
    .multiplier(mplier), .product(product), .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint smul(input logic [W-1:0] a, input logic [W-1:0] b);
    return longint'($signed(a)) * longint'($signed(b));
  endfunction

  // poke: keep start high with other operands on every busy cycle (R6)
  task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                         input bit poke, input string req);
    longint exp;
    logic [P-1:0] held;
    exp = smul(a, b);
    @(negedge clk);
    mcand = a; mplier = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 1; i <= W; i++) begin
      if (poke) begin
        start = 1'b1; mcand = ~a; mplier = b + 1'b1;
      end
      @(negedge clk);
      if (i < W) chk(done == 1'b0, "R2 early done", done, 0);
    end
    start = 1'b0;
    chk(done == 1'b1, "R2 done timing", done, 1);
    chk(longint'($signed(product)) == exp, req, longint'($signed(product)), exp);
    held = product;
    @(negedge clk);
    chk(done == 1'b0, "R5 single pulse", done, 0);
    chk(product == held, "R7 hold after done", product, held);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [P-1:0] held;
    repeat (3) @(negedge clk);
    chk(product == '0, "R1 product in reset", product, 0);
    chk(done == 1'b0, "R1 done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(product == '0 && done == 1'b0, "R1 after reset", product, 0);

    // R3 named examples
    run_mul(4'sd5, -4'sd7, 1'b0, "R3 5*-7");
    run_mul(4'sd5, 4'sd7, 1'b0, "R3 5*7");
    // R4 most negative value
    run_mul(4'b1000, 4'b1000, 1'b0, "R4 -8*-8");
    run_mul(4'b1000, 4'sd7, 1'b0, "R4 -8*7");
    run_mul(4'sd7, 4'b1000, 1'b0, "R4 7*-8");
    // R8 recoding patterns: alternating bits, all ones, zero
    run_mul(4'sd3, 4'b0101, 1'b0, "R8 alt 0101");
    run_mul(4'sd3, 4'b1010, 1'b0, "R8 alt 1010");
    run_mul(-4'sd3, 4'b1111, 1'b0, "R8 all ones");
    run_mul(-4'sd3, 4'b0000, 1'b0, "R8 zero");
    // R6 start held high during busy
    run_mul(4'sd6, -4'sd5, 1'b1, "R6 busy start ignored");
    run_mul(4'b1000, 4'b1000, 1'b1, "R6 busy start ignored minneg");
    @(negedge clk);
    chk(done == 1'b0, "R6 no extra done", done, 0);

    // R7: idle with changing inputs, then product held during next multiply
    held = product;
    for (int k = 0; k < 5; k++) begin
      mcand = W'(k); mplier = W'(k + 3);
      @(negedge clk);
      chk(product == held, "R7 idle hold", product, held);
    end
    mcand = 4'sd2; mplier = 4'sd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 1; i < W; i++) begin
      @(negedge clk);
      chk(product == held, "R7 hold while busy", product, held);
    end
    @(negedge clk);
    chk(longint'($signed(product)) == 6, "R7 new result", longint'($signed(product)), 6);

    // R3 exhaustive sweep, with R6 poking on every third pair
    for (int a = 0; a < (1 << W); a++)
      for (int b = 0; b < (1 << W); b++)
        run_mul(W'(a), W'(b), ((a + b) % 3) == 0, "R3 sweep");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule